// File: doc/BRIEF.md
# System Control Register Bank

A word-addressed register bank for a processor module. A simple single-cycle bus carries a byte address, a write strobe and 32-bit write data; read data is returned combinationally in the same cycle the request is presented. Writes take effect at the next rising clock edge.

The bank holds two oscillator setting registers. They only accept writes while a 16-bit unlock key sits in the lock register. A control register holds an LED bit and a remap bit, and has a write-only reset-request bit that produces a single-cycle pulse. The remap bit decides whether boot flash or RAM is decoded at address zero. Two flag registers are each written through separate set and clear addresses. A free-running reference counter advances on an externally supplied tick enable, so it stays synchronous to the bus clock. A small read-only presence-detect table describes the attached memory, whose size is a parameter that also seeds the SDRAM configuration register.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word 0 (byte 0x00) reads 0x411A3001 and word 4 (byte 0x10) reads 0x00100000. Writes to either have no effect on what they read.
- R2: A write to word 5 (byte 0x14) stores bits [15:0] of the data. A read returns 0x0001A05F while the stored value is 0xA05F, and otherwise returns the stored value zero-extended.
- R3: Word 2 (byte 0x08, reset 0x01000048) and word 7 (byte 0x1C, reset 0x0007FEFF) take a full 32-bit write only while word 5 holds 0xA05F. Otherwise the write is dropped.
- R4: A write to word 3 (byte 0x0C) stores data bits 0 and 2. All other bits read 0. Data bit 3 set in such a write drives `reset_req_o` high for exactly the one cycle after the write edge.
- R5: `remap_o` equals stored control bit 2, which is 0 after reset. The value 0 means boot flash at address zero and the value 1 means RAM there.
- R6: Word 12 (byte 0x30) reads the flags. Writing word 12 ORs the data in, and writing word 13 (byte 0x34) clears every bit written as 1. Words 14 and 15 (bytes 0x38 and 0x3C) do the same for the non-volatile flags, which read at word 14. Both reset to 0.
- R7: Word 10 (byte 0x28) is a 32-bit counter. It resets to 0, increments by one at every clock edge with `ref_tick_i` high, and holds otherwise.
- R8: Byte offsets 0x100 to 0x17F read table entry (offset-0x100)/4, zero-extended. Entry 0 is 0x80, entry 1 is 0x08, entry 2 is 0x04, entry 31 is the density code (2, 4, 16, 32 or 64 for fewer than 32, 32+, 64+, 128+ or 256+ MB), and all other entries are 0. Offsets 0x180 to 0x1FF read 0.
- R9: Word 8 (byte 0x20) resets to 0x00011122 ORed with a size code in bits [4:2]: 0x10 for at least 256 MB, 0x0C for at least 128, 0x08 for at least 64, 0x04 for at least 32, 0 otherwise. Word 9 (byte 0x24) resets to 0x00000112. Both take full 32-bit writes.
- R10: Unimplemented words, including words 11 and 32 to 35, read 0, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as request |
| ref_tick_i | input | 1 | Reference counter tick enable |
| remap_o | output | 1 | 1 selects RAM at address zero, 0 selects boot flash |
| reset_req_o | output | 1 | One-cycle reset request pulse |

## Verification
Two functions can land in the same cycle. The first is a single control write carrying both the reset bit and the remap bit: it must both update the remap output and raise the one-cycle reset pulse, and the reset bit must not stick in readback. The second is a reference tick arriving while the bus reads or writes other registers, which the bench provokes by holding the tick high across a burst of accesses. The counter must still advance by exactly the number of ticked edges, and the other registers must be unaffected.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned W_ID      = 0;
  localparam int unsigned W_OSC     = 2;
  localparam int unsigned W_CTRL    = 3;
  localparam int unsigned W_STAT    = 4;
  localparam int unsigned W_LOCK    = 5;
  localparam int unsigned W_AUXOSC  = 7;
  localparam int unsigned W_SDRAM   = 8;
  localparam int unsigned W_INIT    = 9;
  localparam int unsigned W_REFCNT  = 10;
  localparam int unsigned W_FL_SET  = 12;
  localparam int unsigned W_FL_CLR  = 13;
  localparam int unsigned W_NV_SET  = 14;
  localparam int unsigned W_NV_CLR  = 15;

  localparam logic [31:0] ID_VAL     = 32'h411A_3001;
  localparam logic [31:0] STAT_VAL   = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  function automatic logic [31:0] size_code(int unsigned mb);
    if (mb >= 256)     return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] density(int unsigned mb);
    if (mb >= 256)     return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] spd_byte(logic [4:0] idx, int unsigned mb);
    case (idx)
      5'd0:    return 8'h80;
      5'd1:    return 8'h08;
      5'd2:    return 8'h04;
      5'd31:   return density(mb);
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
#(
  parameter logic [31:0] OSC_INIT = OSC_RST,
  parameter logic [31:0] AUX_INIT = AUX_RST
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lock_i,
  input  logic        wr_osc_i,
  input  logic        wr_aux_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] lock_rd_o,
  output logic [31:0] osc_o,
  output logic [31:0] aux_o
);
  logic [15:0] lock_q;
  logic        unlocked;

  assign unlocked  = (lock_q == UNLOCK_KEY);
  assign lock_rd_o = {15'd0, unlocked, lock_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      osc_o  <= OSC_INIT;
      aux_o  <= AUX_INIT;
    end else begin
      if (wr_lock_i)             lock_q <= wdata_i[15:0];
      if (wr_osc_i && unlocked)  osc_o  <= wdata_i;
      if (wr_aux_i && unlocked)  aux_o  <= wdata_i;
    end
  end

  // R3
  osc_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(osc_o) |-> $past(unlocked));
  // R3
  aux_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(aux_o) |-> $past(unlocked));
endmodule

// File: rtl/sysctl_setclr.sv
module sysctl_setclr #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | data_i;
    else if (clr_i) q_o <= q_o & ~data_i;
  end

  // R6
  clr_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(data_i)) == '0));
  // R6
  set_bits_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(data_i)) == $past(data_i)));
endmodule

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned MEM_MB = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              ref_tick_i,
  output logic              remap_o,
  output logic              reset_req_o
);
  localparam int unsigned NFLAG = 2;
  localparam logic [31:0] SDRAM_INIT = SDRAM_BASE | size_code(MEM_MB);

  logic       in_regs, in_spd;
  logic [5:0] word;
  logic       wr;

  assign in_regs = (addr_i[ADDR_W-1:8] == '0);
  assign in_spd  = (addr_i[ADDR_W-1:8] == 1);
  assign word    = addr_i[7:2];
  assign wr      = req_i && we_i && in_regs;

  function automatic logic hit(logic [5:0] w, int unsigned idx);
    return (w == 6'(idx));
  endfunction

  logic [31:0] lock_rd, osc_q, aux_q;
  sysctl_lock u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lock_i (wr && hit(word, W_LOCK)),
    .wr_osc_i  (wr && hit(word, W_OSC)),
    .wr_aux_i  (wr && hit(word, W_AUXOSC)),
    .wdata_i   (wdata_i),
    .lock_rd_o (lock_rd),
    .osc_o     (osc_q),
    .aux_o     (aux_q)
  );

  // flags[0]: volatile, flags[1]: non-volatile
  logic [NFLAG-1:0] fl_set, fl_clr;
  logic [31:0]      fl_q [NFLAG];
  assign fl_set = {wr && hit(word, W_NV_SET), wr && hit(word, W_FL_SET)};
  assign fl_clr = {wr && hit(word, W_NV_CLR), wr && hit(word, W_FL_CLR)};

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    sysctl_setclr #(.WIDTH(32)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (fl_set[gi]),
      .clr_i  (fl_clr[gi]),
      .data_i (wdata_i),
      .q_o    (fl_q[gi])
    );
  end

  logic [31:0] refcnt;
  sysctl_refcnt #(.CNT_W(32)) u_refcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_tick_i),
    .cnt_o  (refcnt)
  );

  logic        led_q, remap_q;
  logic [31:0] sdram_q, init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q       <= 1'b0;
      remap_q     <= 1'b0;
      reset_req_o <= 1'b0;
      sdram_q     <= SDRAM_INIT;
      init_q      <= INIT_RST;
    end else begin
      reset_req_o <= wr && hit(word, W_CTRL) && wdata_i[3];
      if (wr && hit(word, W_CTRL)) begin
        led_q   <= wdata_i[0];
        remap_q <= wdata_i[2];
      end
      if (wr && hit(word, W_SDRAM)) sdram_q <= wdata_i;
      if (wr && hit(word, W_INIT))  init_q  <= wdata_i;
    end
  end

  assign remap_o = remap_q;

  always_comb begin
    rdata_o = '0;
    if (in_spd) begin
      if (!addr_i[7]) rdata_o = {24'd0, spd_byte(addr_i[6:2], MEM_MB)};
    end else if (in_regs) begin
      case (int'(word))
        W_ID:     rdata_o = ID_VAL;
        W_OSC:    rdata_o = osc_q;
        W_CTRL:   rdata_o = {29'd0, remap_q, 1'b0, led_q};
        W_STAT:   rdata_o = STAT_VAL;
        W_LOCK:   rdata_o = lock_rd;
        W_AUXOSC: rdata_o = aux_q;
        W_SDRAM:  rdata_o = sdram_q;
        W_INIT:   rdata_o = init_q;
        W_REFCNT: rdata_o = refcnt;
        W_FL_SET: rdata_o = fl_q[0];
        W_NV_SET: rdata_o = fl_q[1];
        default:  rdata_o = '0;
      endcase
    end
  end

  // R4
  rst_req_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_regs && word == 6'(W_CTRL) && wdata_i[3]) |=> reset_req_o);
  // R4
  rst_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o);
  // R5
  remap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && in_regs && word == 6'(W_CTRL)) |=> $stable(remap_o));
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam int unsigned ADDR_W = 12;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              ref_tick_i = 1'b0;
  logic              remap_o;
  logic              reset_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sysctl_regs #(.ADDR_W(ADDR_W), .MEM_MB(128)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .ref_tick_i  (ref_tick_i),
    .remap_o     (remap_o),
    .reset_req_o (reset_req_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 id", 12'h000, 32'h411A3001);
    rd_chk("R1 stat", 12'h010, 32'h00100000);
    rd_chk("R3 osc rst", 12'h008, 32'h01000048);
    rd_chk("R3 aux rst", 12'h01C, 32'h0007FEFF);
    rd_chk("R9 sdram rst", 12'h020, 32'h0001112E);
    rd_chk("R9 init rst", 12'h024, 32'h00000112);
    rd_chk("R7 cnt rst", 12'h028, 32'h0);
    rd_chk("R2 lock rst", 12'h014, 32'h0);
    check("R5 remap rst", {31'd0, remap_o}, 32'd0);
    check("R4 rstreq idle", {31'd0, reset_req_o}, 32'd0);
  endtask

  task automatic t_lock_osc;
    wr(12'h008, 32'h12345678);
    rd_chk("R3 osc locked", 12'h008, 32'h01000048);
    wr(12'h014, 32'hFFFF_A05F);
    rd_chk("R2 unlocked read", 12'h014, 32'h0001A05F);
    wr(12'h008, 32'hCAFE0001);
    wr(12'h01C, 32'hBEEF0002);
    rd_chk("R3 osc write", 12'h008, 32'hCAFE0001);
    rd_chk("R3 aux write", 12'h01C, 32'hBEEF0002);
    wr(12'h014, 32'h0001_1234);
    rd_chk("R2 locked read", 12'h014, 32'h00001234);
    wr(12'h01C, 32'h0);
    rd_chk("R3 aux relocked", 12'h01C, 32'hBEEF0002);
  endtask

  task automatic t_ctrl;
    wr(12'h00C, 32'hFFFF_FFF7);
    rd_chk("R4 ctrl bits", 12'h00C, 32'h5);
    check("R5 remap set", {31'd0, remap_o}, 32'd1);
    check("R4 no pulse", {31'd0, reset_req_o}, 32'd0);
    wr(12'h00C, 32'h0);
    check("R5 remap clr", {31'd0, remap_o}, 32'd0);
    // reset bit together with remap bit in one write
    wr(12'h00C, 32'hC);
    @(negedge clk_i);
    check("R4 pulse high", {31'd0, reset_req_o}, 32'd1);
    check("R5 remap with reset", {31'd0, remap_o}, 32'd1);
    @(negedge clk_i);
    check("R4 pulse ends", {31'd0, reset_req_o}, 32'd0);
    rd_chk("R4 bit3 reads 0", 12'h00C, 32'h4);
  endtask

  task automatic t_flags;
    wr(12'h030, 32'h0000_00F0);
    wr(12'h030, 32'h0001_0001);
    rd_chk("R6 flag set", 12'h030, 32'h000100F1);
    wr(12'h034, 32'h0000_0030);
    rd_chk("R6 flag clr", 12'h030, 32'h000100C1);
    rd_chk("R6 nv untouched", 12'h038, 32'h0);
    wr(12'h038, 32'hA000_0005);
    wr(12'h03C, 32'h2000_0001);
    rd_chk("R6 nv setclr", 12'h038, 32'h80000004);
    rd_chk("R6 flag untouched", 12'h030, 32'h000100C1);
  endtask

  task automatic t_counter;
    logic [31:0] c0, c1;
    rd(12'h028, c0);
    repeat (4) @(negedge clk_i);
    rd_chk("R7 hold", 12'h028, c0);
    @(negedge clk_i);
    ref_tick_i = 1'b1;
    repeat (7) @(posedge clk_i);
    #1 ref_tick_i = 1'b0;
    rd_chk("R7 seven ticks", 12'h028, c0 + 32'd7);
    // ticks concurrent with bus traffic
    rd(12'h028, c1);
    @(negedge clk_i);
    ref_tick_i = 1'b1;
    wr(12'h024, 32'h0000_0ABC);
    wr(12'h030, 32'h0000_0100);
    #1 ref_tick_i = 1'b0;
    rd_chk("R7 ticks during writes", 12'h028, c1 + 32'd3);
    rd_chk("R9 init write", 12'h024, 32'h00000ABC);
    rd_chk("R6 set during tick", 12'h030, 32'h000101C1);
  endtask

  task automatic t_spd;
    rd_chk("R8 entry0", 12'h100, 32'h80);
    rd_chk("R8 entry1", 12'h104, 32'h08);
    rd_chk("R8 entry2", 12'h108, 32'h04);
    rd_chk("R8 entry5", 12'h114, 32'h00);
    rd_chk("R8 entry31", 12'h17C, 32'd32);
    rd_chk("R8 upper zero", 12'h180, 32'h0);
    rd_chk("R8 top zero", 12'h1FC, 32'h0);
  endtask

  task automatic t_sdram;
    wr(12'h020, 32'h5A5A_A5A5);
    rd_chk("R9 sdram write", 12'h020, 32'h5A5AA5A5);
  endtask

  task automatic t_unimpl;
    wr(12'h02C, 32'hFFFF_FFFF);
    rd_chk("R10 word11", 12'h02C, 32'h0);
    wr(12'h080, 32'h1234_5678);
    rd_chk("R10 word32", 12'h080, 32'h0);
    rd_chk("R10 word35", 12'h08C, 32'h0);
    wr(12'h000, 32'h0);
    rd_chk("R1 id after write", 12'h000, 32'h411A3001);
    wr(12'h010, 32'h0);
    rd_chk("R1 stat after write", 12'h010, 32'h00100000);
    rd_chk("R10 other regs intact", 12'h030, 32'h000101C1);
    rd_chk("R10 sdram intact", 12'h020, 32'h5A5AA5A5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_lock_osc();
    t_ctrl();
    t_flags();
    t_counter();
    t_spd();
    t_sdram();
    t_unimpl();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule